// File: doc/BRIEF.md
# Framed Asynchronous Transmit Quadlet Queue

This block buffers outgoing asynchronous packets one 32-bit quadlet at a time. A host places quadlets with two write strobes: one for quadlets that continue a packet and one for the quadlet that closes it. Every accepted quadlet passes through a one-entry staging register before it reaches storage. A host-visible flag drops while a quadlet sits in staging and rises again once it is stored.

The host sees occupancy at several levels: empty, at least five entries free, exactly one entry free, and full. A write that cannot be stored sets a sticky error bit. The host clears that bit with a write-one strobe.

A downstream reader sees a packet-ready indication only once at least one complete packet is in storage. It receives the oldest quadlet together with a flag marking the end of the packet, and pops that quadlet with a read strobe.

Top module: `async_tx_queue`

## Requirements
- R1: A quadlet written on the continue port is delivered with `rd_last_o`=0. A quadlet written on the close port is delivered with `rd_last_o`=1. Quadlets leave in the order they were written.
- R2: `pkt_avail_o` is high only while storage holds at least one quadlet written on the close port. It stays high until the reader pops that quadlet. A read strobe while `pkt_avail_o` is low removes nothing.
- R3: `full_o` is 1 exactly when no entry is free. Occupancy counts stored quadlets plus one staged quadlet.
- R4: `almost_full_o` is 1 exactly when one entry is free.
- R5: `five_free_o` is 1 exactly when five or more entries are free.
- R6: `empty_o` is 1 exactly when occupancy is zero. It falls in the cycle after an accepted write.
- R7: `written_o` falls in the cycle after an accepted write. It returns to 1 one cycle later, unless another write was accepted in that cycle.
- R8: A write while `full_o` is 1 is dropped. It sets `wr_err_o` in the next cycle and leaves the stored contents unchanged.
- R9: Raising both write strobes in the same cycle stores nothing and sets `wr_err_o`. It leaves `written_o` at 1.
- R10: `err_clr_i` clears `wr_err_o` in the next cycle. A new error in the same cycle takes priority and leaves the bit set.
- R11: After reset the outputs read as follows: `empty_o`=1, `five_free_o`=1, `written_o`=1, `full_o`=0, `almost_full_o`=0, `wr_err_o`=0 and `pkt_avail_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| next_we_i | input | 1 | Write strobe for a quadlet that continues a packet |
| next_data_i | input | 32 | Data for the continue port |
| last_we_i | input | 1 | Write strobe for the quadlet that closes a packet |
| last_data_i | input | 32 | Data for the close port |
| err_clr_i | input | 1 | Write-one strobe that clears the error flag |
| full_o | output | 1 | No entry free |
| almost_full_o | output | 1 | Exactly one entry free |
| five_free_o | output | 1 | At least five entries free |
| empty_o | output | 1 | Occupancy is zero |
| written_o | output | 1 | Last accepted quadlet has reached storage |
| wr_err_o | output | 1 | Sticky write-error flag |
| pkt_avail_o | output | 1 | A complete packet is ready for the reader |
| rd_i | input | 1 | Reader pops the head quadlet |
| rd_data_o | output | 32 | Head quadlet |
| rd_last_o | output | 1 | Head quadlet closes its packet |

## Verification
Three situations are hard to reach from the ports. The first is a write that arrives exactly when the last entry is taken: the bench fills the queue with back-to-back single-cycle writes and samples the graded flags at 27, 28, 31 and 32 entries. The second is a write against the full queue that coincides with a clear strobe, which checks that the new error wins over the clear. The third is a read strobe issued while only continuation quadlets are stored. The scoreboard later shows that none of those quadlets was lost or reordered.

// File: rtl/async_txq_pkg.sv
package async_txq_pkg;
  localparam int unsigned QUAD_W = 32;

  typedef struct packed {
    logic              last;
    logic [QUAD_W-1:0] data;
  } txq_entry_t;
endpackage

// File: rtl/txq_stage.sv
module txq_stage
  import async_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              next_we_i,
  input  logic [QUAD_W-1:0] next_data_i,
  input  logic              last_we_i,
  input  logic [QUAD_W-1:0] last_data_i,
  input  logic              err_clr_i,
  input  logic [CNT_W-1:0]  used_i,
  output logic              stage_v_o,
  output txq_entry_t        stage_q_o,
  output logic              wr_err_o
);
  logic any_we, collide, room, accept;

  assign any_we  = next_we_i | last_we_i;
  assign collide = next_we_i & last_we_i;
  assign room    = used_i < CNT_W'(DEPTH);
  assign accept  = any_we & ~collide & room;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_v_o <= 1'b0;
      stage_q_o <= '0;
    end else begin
      stage_v_o <= accept;
      if (accept) begin
        stage_q_o.last <= last_we_i;
        stage_q_o.data <= last_we_i ? last_data_i : next_data_i;
      end
    end
  end

  // new error wins over host clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               wr_err_o <= 1'b0;
    else if (any_we && !accept) wr_err_o <= 1'b1;
    else if (err_clr_i)        wr_err_o <= 1'b0;
  end
endmodule

// File: rtl/txq_store.sv
module txq_store
  import async_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  txq_entry_t       push_entry_i,
  input  logic             pop_req_i,
  output txq_entry_t       head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             pkt_avail_o
);
  txq_entry_t       mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] pkt_cnt;
  logic             pop, push_last, pop_last;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pkt_avail_o = pkt_cnt != '0;
  assign pop         = pop_req_i & pkt_avail_o;
  assign head_o      = mem[rd_ptr];
  assign push_last   = push_i & push_entry_i.last;
  assign pop_last    = pop & head_o.last;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= push_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
      pkt_cnt <= '0;
    end else begin
      if (push_i) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)    rd_ptr <= ptr_inc(rd_ptr);
      count_o <= count_o + CNT_W'(push_i) - CNT_W'(pop);
      pkt_cnt <= pkt_cnt + CNT_W'(push_last) - CNT_W'(pop_last);
    end
  end
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] used_i,
  output logic             full_o,
  output logic             almost_full_o,
  output logic             five_free_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] free;

  assign free          = CNT_W'(DEPTH) - used_i;
  assign full_o        = free == '0;
  assign almost_full_o = free == CNT_W'(1);
  assign empty_o       = used_i == '0;

  generate
    if (DEPTH >= 5) begin : g_five
      assign five_free_o = free >= CNT_W'(5);
    end else begin : g_small
      assign five_free_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/async_tx_queue.sv
module async_tx_queue
  import async_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        next_we_i,
  input  logic [31:0] next_data_i,
  input  logic        last_we_i,
  input  logic [31:0] last_data_i,
  input  logic        err_clr_i,
  output logic        full_o,
  output logic        almost_full_o,
  output logic        five_free_o,
  output logic        empty_o,
  output logic        written_o,
  output logic        wr_err_o,
  output logic        pkt_avail_o,
  input  logic        rd_i,
  output logic [31:0] rd_data_o,
  output logic        rd_last_o
);
  logic             stage_v;
  txq_entry_t       stage_q, head;
  logic [CNT_W-1:0] count, used;

  assign used      = count + CNT_W'(stage_v);
  assign written_o = ~stage_v;
  assign rd_data_o = head.data;
  assign rd_last_o = head.last;

  txq_stage #(.DEPTH(DEPTH)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .next_we_i   (next_we_i),
    .next_data_i (next_data_i),
    .last_we_i   (last_we_i),
    .last_data_i (last_data_i),
    .err_clr_i   (err_clr_i),
    .used_i      (used),
    .stage_v_o   (stage_v),
    .stage_q_o   (stage_q),
    .wr_err_o    (wr_err_o)
  );

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (stage_v),
    .push_entry_i (stage_q),
    .pop_req_i    (rd_i),
    .head_o       (head),
    .count_o      (count),
    .pkt_avail_o  (pkt_avail_o)
  );

  txq_flags #(.DEPTH(DEPTH)) u_flags (
    .used_i        (used),
    .full_o        (full_o),
    .almost_full_o (almost_full_o),
    .five_free_o   (five_free_o),
    .empty_o       (empty_o)
  );
endmodule

// File: rtl/async_tx_queue_chk.sv
module async_tx_queue_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic next_we_i,
  input logic last_we_i,
  input logic err_clr_i,
  input logic full_o,
  input logic almost_full_o,
  input logic five_free_o,
  input logic empty_o,
  input logic written_o,
  input logic wr_err_o,
  input logic pkt_avail_o,
  input logic rd_i
);
  a_r8_full_write_errs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && (next_we_i ^ last_we_i) |=> wr_err_o);

  a_r9_collision_errs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_we_i && last_we_i |=> wr_err_o);

  a_r7_written_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_we_i ^ last_we_i) && !full_o |=> !written_o);

  a_r7_written_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !written_o && !next_we_i && !last_we_i |=> written_o);

  a_r10_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !next_we_i && !last_we_i |=> !wr_err_o);

  a_r4_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({full_o, almost_full_o, five_free_o, empty_o && full_o}));

  a_r2_pkt_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_avail_o |-> !empty_o);

  a_r2_pkt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_avail_o && !rd_i |=> pkt_avail_o);
endmodule

bind async_tx_queue async_tx_queue_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .next_we_i     (next_we_i),
  .last_we_i     (last_we_i),
  .err_clr_i     (err_clr_i),
  .full_o        (full_o),
  .almost_full_o (almost_full_o),
  .five_free_o   (five_free_o),
  .empty_o       (empty_o),
  .written_o     (written_o),
  .wr_err_o      (wr_err_o),
  .pkt_avail_o   (pkt_avail_o),
  .rd_i          (rd_i)
);

// File: tb/test_async_tx_queue.sv
`timescale 1ns/1ps
module test_async_tx_queue;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic next_we = 1'b0, last_we = 1'b0, err_clr = 1'b0;
  logic [31:0] next_data = '0, last_data = '0;
  logic full, almost_full, five_free, empty, written, wr_err, pkt_avail;
  logic rd, rd_last;
  logic [31:0] rd_data;
  logic drain_en = 1'b0, rd_force = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [32:0] sb[$];

  always #2 clk = ~clk;
  assign rd = drain_en | rd_force;

  async_tx_queue #(.DEPTH(DEPTH)) i_async_tx_queue (
    .clk_i(clk), .rst_ni(rst_ni),
    .next_we_i(next_we), .next_data_i(next_data),
    .last_we_i(last_we), .last_data_i(last_data),
    .err_clr_i(err_clr),
    .full_o(full), .almost_full_o(almost_full), .five_free_o(five_free),
    .empty_o(empty), .written_o(written), .wr_err_o(wr_err),
    .pkt_avail_o(pkt_avail), .rd_i(rd), .rd_data_o(rd_data), .rd_last_o(rd_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_flags(input int n, input string req);
    int fr = DEPTH - n;
    chk(full == (fr == 0), {req, " R3 full"}, full, fr == 0);
    chk(almost_full == (fr == 1), {req, " R4 almost_full"}, almost_full, fr == 1);
    chk(five_free == (fr >= 5), {req, " R5 five_free"}, five_free, fr >= 5);
    chk(empty == (n == 0), {req, " R6 empty"}, empty, n == 0);
  endtask

  // driver: one-cycle strobe, pushes expected item when it must be accepted
  task automatic wr(input bit nx, input bit ls, input logic [31:0] d);
    @(negedge clk);
    next_we = nx; last_we = ls; next_data = d; last_data = d;
    if ((nx ^ ls) && sb.size() < DEPTH) sb.push_back({ls, d});
    @(posedge clk); #1;
    next_we = 1'b0; last_we = 1'b0;
  endtask

  task automatic clr_err();
    @(negedge clk); err_clr = 1'b1;
    @(posedge clk); #1; err_clr = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk); drain_en = 1'b1;
    while (sb.size() != 0) @(posedge clk);
    @(negedge clk); drain_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: compares each popped quadlet with the scoreboard (R1)
  always begin
    @(negedge clk); #1;
    if (rst_ni && rd && pkt_avail) begin
      if (sb.size() == 0) chk(1'b0, "R1 unexpected pop", {rd_last, rd_data}, 0);
      else begin
        chk({rd_last, rd_data} == sb[0], "R1 data/last order", {rd_last, rd_data}, sb[0]);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(empty && five_free && written && !full && !almost_full && !wr_err && !pkt_avail,
        "R11 reset", {empty, five_free, written, full, almost_full, wr_err, pkt_avail}, 7'b1110000);

    // R7 written handshake
    wr(1'b1, 1'b0, 32'h1111_0001);
    chk(!written, "R7 written low after write", written, 0);
    check_flags(1, "R6 after first write");
    @(posedge clk); #1;
    chk(written, "R7 written back high", written, 1);
    wr(1'b1, 1'b0, 32'h1111_0002);
    @(posedge clk); #1;
    chk(!pkt_avail, "R2 no packet before close", pkt_avail, 0);
    // R2 read while no packet is ignored
    @(negedge clk); rd_force = 1'b1;
    repeat (2) @(negedge clk); rd_force = 1'b0;
    @(posedge clk); #1;
    check_flags(2, "R2 read ignored");
    wr(1'b0, 1'b1, 32'h1111_0003);
    chk(!pkt_avail, "R2 close still staged", pkt_avail, 0);
    @(posedge clk); #1;
    chk(pkt_avail, "R2 packet ready", pkt_avail, 1);
    drain();
    check_flags(0, "R6 drained");
    chk(!pkt_avail, "R2 none left", pkt_avail, 0);

    // fill with 4-quadlet packets, graded flags
    for (int i = 0; i < DEPTH; i++) begin
      wr(i % 4 != 3, i % 4 == 3, 32'hA500_0000 + i);
      if (i + 1 == DEPTH - 5) check_flags(i + 1, "R5 five free");
      if (i + 1 == DEPTH - 4) check_flags(i + 1, "R5 four free");
      if (i + 1 == DEPTH - 1) check_flags(i + 1, "R4 one free");
      if (i + 1 == DEPTH)     check_flags(i + 1, "R3 full");
    end
    chk(!wr_err, "R8 no error yet", wr_err, 0);
    wr(1'b1, 1'b0, 32'hDEAD_BEEF);
    chk(wr_err, "R8 full write errors", wr_err, 1);
    chk(written, "R8 written untouched", written, 1);
    check_flags(DEPTH, "R8 contents kept");
    clr_err();
    chk(!wr_err, "R10 clear", wr_err, 0);
    // R10 error set beats clear
    @(negedge clk); err_clr = 1'b1; last_we = 1'b1; last_data = 32'hBAD0_0000;
    @(posedge clk); #1; err_clr = 1'b0; last_we = 1'b0;
    chk(wr_err, "R10 set wins", wr_err, 1);
    clr_err();
    drain();
    check_flags(0, "R6 drained after full");

    // R9 collision
    @(negedge clk); next_we = 1'b1; last_we = 1'b1;
    next_data = 32'hC0C0_0001; last_data = 32'hC0C0_0002;
    @(posedge clk); #1; next_we = 1'b0; last_we = 1'b0;
    chk(wr_err, "R9 collision error", wr_err, 1);
    chk(written, "R9 written stays", written, 1);
    @(posedge clk); #1;
    check_flags(0, "R9 nothing stored");
    clr_err();

    // single-quadlet packets
    wr(1'b0, 1'b1, 32'h5151_0001);
    wr(1'b0, 1'b1, 32'h5151_0002);
    @(posedge clk); #1;
    chk(pkt_avail && rd_last, "R1 single close", rd_last, 1);
    drain();
    chk(sb.size() == 0, "R1 scoreboard empty", sb.size(), 0);
    finish_run();
  end
endmodule